// File: doc/BRIEF.md
# Windowed Integer Register File

This block holds the integer registers of a processor that gives every subroutine a fresh set of working registers by sliding a window over a larger physical array. A 5-bit register number from the pipeline is turned into a physical entry using the current window pointer. Eight registers are common to all windows. Eight are private to one window. The remaining sixteen overlap with the two neighbouring windows, so a caller's argument registers appear as the callee's incoming registers without any data being copied.

Save and restore commands move the window pointer down or up by one, wrapping at the window count. A per-window invalid mask marks the windows that may not be entered. A move that would land on a marked window is refused, and an overflow or underflow flag is raised so that trap logic outside this block can spill or refill a window and retry. The block has two combinational read ports, one write port, a port that loads the mask, and a readback of the window pointer.

Top module: `wrf_top`

## Requirements
- R1: Register numbers 0 to 7 select the same global entries whatever the window pointer holds.
- R2: Register 0 always reads as zero, including in the cycle it is written, and any value written to it is lost.
- R3: A save moves the window pointer to (pointer - 1) mod NWIN and a restore moves it to (pointer + 1) mod NWIN, so 0 goes to NWIN-1 on a save and NWIN-1 goes to 0 on a restore.
- R4: After a save and a matching restore, the locals (16 to 23) and outputs (8 to 15) of the original window read back unchanged.
- R5: Mask bit k set to 1 marks window k invalid and 0 marks it valid; the mask is loaded from the mask port on a clock edge. A save whose target window is invalid raises the overflow flag. A restore whose target window is invalid raises the underflow flag.
- R6: A refused save or restore leaves the window pointer unchanged. Its flag is high only in the cycle after the request, and neither flag is high after a cycle that has no request.
- R7: Locals (16 to 23) are private to each window. Inputs (24 to 31) of window W are the same storage as outputs (8 to 15) of window (W + 1) mod NWIN.
- R8: A value written to register 15 reads as register 31 after a save into the next window down.
- R9: NWIN must be a power of two from 2 to 32 (default 8), which gives pointer values 0 to NWIN-1. Any other value stops elaboration.
- R10: After reset the window pointer is NWIN-1, only mask bit NWIN-2 is set, and every register reads zero.
- R11: Save and restore take effect at the clock edge. Reads in the same cycle as the request still use the old window, and reads in the next cycle use the new one.
- R12: A read of the entry being written in the same cycle returns the data being written.
- R13: A save and a restore requested in the same cycle are both ignored: the pointer does not change and no flag is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| save_req | input | 1 | Move to the next window down |
| restore_req | input | 1 | Move to the next window up |
| wim_wr_en | input | 1 | Load the invalid-window mask |
| wim_wr_data | input | NWIN | New mask value, bit k for window k |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 5 | Register number written |
| wr_data | input | XLEN | Data written |
| rd_a_addr | input | 5 | Register number for read port A |
| rd_a_data | output | XLEN | Read port A data |
| rd_b_addr | input | 5 | Register number for read port B |
| rd_b_data | output | XLEN | Read port B data |
| cwp_o | output | $clog2(NWIN) | Current window pointer |
| ovf_trap | output | 1 | Overflow flag, one cycle |
| unf_trap | output | 1 | Underflow flag, one cycle |

## Verification
The bench writes a distinct value into each register group and then moves the window. A global, a private local, and an output/input pair each give a different readback after a save. This distinguishes a correct mapping from one that shares too much or too little. A series of saves runs against a mask with a single invalid bit, and a later series wraps through window 0. These separate a trap decision made on the target window from one made on the current window, and they expose a pointer that fails to wrap. Same-cycle cases are run separately: a write and a read together, a request and a read together, and save with restore. These check bypass and edge timing independently of the steady-state mapping.

// File: rtl/wrf_pkg.sv
`timescale 1ns/1ps
package wrf_pkg;
   localparam int GRP_SIZE = 8;
   localparam int ARCH_AW  = 5;

   typedef enum logic [1:0] {
      GRP_GLB = 2'd0,
      GRP_OUT = 2'd1,
      GRP_LOC = 2'd2,
      GRP_IN  = 2'd3
   } reg_grp_e;

   typedef enum logic [1:0] {
      WOP_NONE    = 2'd0,
      WOP_SAVE    = 2'd1,
      WOP_RESTORE = 2'd2
   } win_op_e;
endpackage

// File: rtl/wrf_addr_map.sv
`timescale 1ns/1ps
module wrf_addr_map #(
   parameter int NWIN = 8,
   parameter int PAW  = 8,
   localparam int CWPW = $clog2(NWIN)
) (
   input  logic [CWPW-1:0]              cwp,
   input  logic [wrf_pkg::ARCH_AW-1:0]  arch,
   output logic [PAW-1:0]               phys
);
   import wrf_pkg::*;

   reg_grp_e        grp;
   logic [2:0]      off;
   logic [CWPW-1:0] slot;
   logic            half;

   assign grp = reg_grp_e'(arch[4:3]);
   assign off = arch[2:0];

   // Each window owns 16 entries past the globals: outputs first, locals second.
   // Inputs alias the output half of the window one above.
   always_comb begin
      slot = cwp;
      half = 1'b0;
      unique case (grp)
         GRP_OUT: begin slot = cwp;              half = 1'b0; end
         GRP_LOC: begin slot = cwp;              half = 1'b1; end
         GRP_IN:  begin slot = cwp + CWPW'(1);   half = 1'b0; end
         default: begin slot = cwp;              half = 1'b0; end
      endcase
      if (grp == GRP_GLB) phys = PAW'(off);
      else                phys = PAW'({slot, half, off}) + PAW'(GRP_SIZE);
   end
endmodule

// File: rtl/wrf_window_ctl.sv
`timescale 1ns/1ps
module wrf_window_ctl #(
   parameter int NWIN = 8,
   localparam int CWPW = $clog2(NWIN)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            save_req,
   input  logic            restore_req,
   input  logic            wim_we,
   input  logic [NWIN-1:0] wim_wd,
   output logic [CWPW-1:0] cwp_q,
   output logic [NWIN-1:0] wim_q,
   output logic            ovf_q,
   output logic            unf_q
);
   import wrf_pkg::*;

   win_op_e         op;
   logic [CWPW-1:0] tgt_dn;
   logic [CWPW-1:0] tgt_up;

   always_comb begin
      if (save_req && !restore_req)      op = WOP_SAVE;
      else if (restore_req && !save_req) op = WOP_RESTORE;
      else                               op = WOP_NONE;
   end

   assign tgt_dn = cwp_q - CWPW'(1);
   assign tgt_up = cwp_q + CWPW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cwp_q <= CWPW'(NWIN - 1);
         wim_q <= NWIN'(1) << (NWIN - 2);
         ovf_q <= 1'b0;
         unf_q <= 1'b0;
      end else begin
         ovf_q <= 1'b0;
         unf_q <= 1'b0;
         if (wim_we) wim_q <= wim_wd;
         unique case (op)
            WOP_SAVE: begin
               if (wim_q[tgt_dn]) ovf_q <= 1'b1;
               else               cwp_q <= tgt_dn;
            end
            WOP_RESTORE: begin
               if (wim_q[tgt_up]) unf_q <= 1'b1;
               else               cwp_q <= tgt_up;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/wrf_storage.sv
`timescale 1ns/1ps
module wrf_storage #(
   parameter int NPHYS = 136,
   parameter int PAW   = 8,
   parameter int XLEN  = 32,
   parameter int NRD   = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      we,
   input  logic [PAW-1:0]            wa,
   input  logic [XLEN-1:0]           wd,
   input  logic [NRD-1:0][PAW-1:0]   ra,
   output logic [NRD-1:0][XLEN-1:0]  rd
);
   logic [XLEN-1:0] mem [NPHYS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NPHYS; i++) mem[i] <= '0;
      end else if (we) begin
         mem[wa] <= wd;
      end
   end

   for (genvar p = 0; p < NRD; p++) begin : g_rd
      assign rd[p] = (we && (wa == ra[p])) ? wd : mem[ra[p]];
   end
endmodule

// File: rtl/wrf_top.sv
`timescale 1ns/1ps
module wrf_top #(
   parameter int NWIN = 8,
   parameter int XLEN = 32,
   localparam int CWPW = $clog2(NWIN)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            save_req,
   input  logic            restore_req,
   input  logic            wim_wr_en,
   input  logic [NWIN-1:0] wim_wr_data,
   input  logic            wr_en,
   input  logic [4:0]      wr_addr,
   input  logic [XLEN-1:0] wr_data,
   input  logic [4:0]      rd_a_addr,
   output logic [XLEN-1:0] rd_a_data,
   input  logic [4:0]      rd_b_addr,
   output logic [XLEN-1:0] rd_b_data,
   output logic [CWPW-1:0] cwp_o,
   output logic            ovf_trap,
   output logic            unf_trap
);
   import wrf_pkg::*;

   localparam int NPHYS = GRP_SIZE + 2 * GRP_SIZE * NWIN;
   localparam int PAW   = $clog2(NPHYS);
   localparam int NRD   = 2;
   localparam int NMAP  = NRD + 1;

   if (NWIN < 2 || NWIN > 32 || (NWIN & (NWIN - 1)) != 0) begin : g_bad_nwin
      $error("wrf_top: NWIN must be a power of two in 2..32");
   end

   logic [CWPW-1:0]             cwp_q;
   logic [NWIN-1:0]             wim_q;
   logic [NMAP-1:0][4:0]        arch_addr;
   logic [NMAP-1:0][PAW-1:0]    phys_addr;
   logic [NRD-1:0][PAW-1:0]     rd_phys;
   logic [NRD-1:0][XLEN-1:0]    rd_word;
   logic                        wr_live;

   assign arch_addr[0] = rd_a_addr;
   assign arch_addr[1] = rd_b_addr;
   assign arch_addr[2] = wr_addr;

   for (genvar m = 0; m < NMAP; m++) begin : g_map
      wrf_addr_map #(.NWIN(NWIN), .PAW(PAW)) u_map (
         .cwp  (cwp_q),
         .arch (arch_addr[m]),
         .phys (phys_addr[m])
      );
   end

   for (genvar p = 0; p < NRD; p++) begin : g_rsel
      assign rd_phys[p] = phys_addr[p];
   end

   // Register 0 is never stored, so its entry stays at the reset value.
   assign wr_live = wr_en && (wr_addr != 5'd0);

   wrf_storage #(.NPHYS(NPHYS), .PAW(PAW), .XLEN(XLEN), .NRD(NRD)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_live),
      .wa    (phys_addr[NMAP-1]),
      .wd    (wr_data),
      .ra    (rd_phys),
      .rd    (rd_word)
   );

   wrf_window_ctl #(.NWIN(NWIN)) u_win (
      .clk         (clk),
      .rst_n       (rst_n),
      .save_req    (save_req),
      .restore_req (restore_req),
      .wim_we      (wim_wr_en),
      .wim_wd      (wim_wr_data),
      .cwp_q       (cwp_q),
      .wim_q       (wim_q),
      .ovf_q       (ovf_trap),
      .unf_q       (unf_trap)
   );

   assign rd_a_data = rd_word[0];
   assign rd_b_data = rd_word[1];
   assign cwp_o     = cwp_q;
endmodule

// File: rtl/wrf_chk.sv
`timescale 1ns/1ps
module wrf_chk #(
   parameter int NWIN = 8,
   parameter int XLEN = 32,
   localparam int CWPW = $clog2(NWIN)
) (
   input logic            clk,
   input logic            rst_n,
   input logic            save_req,
   input logic            restore_req,
   input logic [4:0]      rd_a_addr,
   input logic [XLEN-1:0] rd_a_data,
   input logic [CWPW-1:0] cwp_o,
   input logic [NWIN-1:0] wim_q,
   input logic            ovf_trap,
   input logic            unf_trap
);
   logic [CWPW-1:0] dn;
   logic [CWPW-1:0] up;
   logic            only_save;
   logic            only_rest;

   assign dn        = cwp_o - CWPW'(1);
   assign up        = cwp_o + CWPW'(1);
   assign only_save = save_req && !restore_req;
   assign only_rest = restore_req && !save_req;

   a_r2_zero_read: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_a_addr == 5'd0) |-> (rd_a_data == '0));

   a_r3_save_moves: assert property (@(posedge clk) disable iff (!rst_n)
      (only_save && !wim_q[dn]) |=> (cwp_o == $past(dn)));

   a_r3_restore_moves: assert property (@(posedge clk) disable iff (!rst_n)
      (only_rest && !wim_q[up]) |=> (cwp_o == $past(up)));

   a_r5_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (only_save && wim_q[dn]) |=> (ovf_trap && !unf_trap));

   a_r5_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      (only_rest && wim_q[up]) |=> (unf_trap && !ovf_trap));

   a_r6_cwp_held: assert property (@(posedge clk) disable iff (!rst_n)
      (only_save && wim_q[dn]) |=> $stable(cwp_o));

   a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      (!save_req && !restore_req) |=> (!ovf_trap && !unf_trap));

   a_r13_both_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (save_req && restore_req) |=> (!ovf_trap && !unf_trap && $stable(cwp_o)));
endmodule

bind wrf_top wrf_chk #(.NWIN(NWIN), .XLEN(XLEN)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .save_req    (save_req),
   .restore_req (restore_req),
   .rd_a_addr   (rd_a_addr),
   .rd_a_data   (rd_a_data),
   .cwp_o       (cwp_o),
   .wim_q       (wim_q),
   .ovf_trap    (ovf_trap),
   .unf_trap    (unf_trap)
);

// File: tb/sim_wrf_top.sv
`timescale 1ns/1ps
module sim_wrf_top;
   localparam int NWIN = 8;
   localparam int XLEN = 32;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            save_req = 1'b0, restore_req = 1'b0;
   logic            wim_wr_en = 1'b0;
   logic [NWIN-1:0] wim_wr_data = '0;
   logic            wr_en = 1'b0;
   logic [4:0]      wr_addr = '0;
   logic [XLEN-1:0] wr_data = '0;
   logic [4:0]      rd_a_addr = '0, rd_b_addr = '0;
   logic [XLEN-1:0] rd_a_data, rd_b_data;
   logic [2:0]      cwp_o;
   logic            ovf_trap, unf_trap;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   typedef struct {
      bit          ca;
      logic [31:0] ea;
      bit          cb;
      logic [31:0] eb;
      int          ecwp;
      bit          eo;
      bit          eu;
      string       tag;
   } exp_t;
   exp_t sb[$];

   localparam logic [31:0] A1  = 32'hA1A1_0008;
   localparam logic [31:0] G1  = 32'h1111_0001;
   localparam logic [31:0] RET = 32'hCAFE_0015;
   localparam logic [31:0] L7  = 32'h7777_0016;
   localparam logic [31:0] L6  = 32'h6666_0016;

   always #10 clk = ~clk;

   wrf_top #(.NWIN(NWIN), .XLEN(XLEN)) u0 (
      .clk(clk), .rst_n(rst_n), .save_req(save_req), .restore_req(restore_req),
      .wim_wr_en(wim_wr_en), .wim_wr_data(wim_wr_data), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_a_addr(rd_a_addr),
      .rd_a_data(rd_a_data), .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data),
      .cwp_o(cwp_o), .ovf_trap(ovf_trap), .unf_trap(unf_trap)
   );

   // Driver: one call per cycle. Reads are checked against this cycle's
   // addresses; pointer and flags show the effect of earlier edges.
   task automatic cyc(input bit sv, input bit rs, input bit we, input logic [4:0] wa,
                      input logic [31:0] wd, input bit ww, input logic [7:0] wimd,
                      input logic [4:0] ra, input bit ca, input logic [31:0] ea,
                      input logic [4:0] rb, input bit cb, input logic [31:0] eb,
                      input int ecwp, input bit eo, input bit eu, input string tag);
      exp_t e;
      @(negedge clk);
      save_req = sv; restore_req = rs; wr_en = we; wr_addr = wa; wr_data = wd;
      wim_wr_en = ww; wim_wr_data = wimd; rd_a_addr = ra; rd_b_addr = rb;
      e.ca = ca; e.ea = ea; e.cb = cb; e.eb = eb;
      e.ecwp = ecwp; e.eo = eo; e.eu = eu; e.tag = tag;
      sb.push_back(e);
   endtask

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
      end
   endtask

   // Monitor: samples mid-cycle, away from both edges.
   initial begin
      forever begin
         @(negedge clk);
         #5;
         if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            if (e.ca) chk(rd_a_data === e.ea, e.tag, "rd_a", rd_a_data, e.ea);
            if (e.cb) chk(rd_b_data === e.eb, e.tag, "rd_b", rd_b_data, e.eb);
            chk(cwp_o === 3'(e.ecwp), e.tag, "cwp", 32'(cwp_o), 32'(e.ecwp));
            chk(ovf_trap === e.eo, e.tag, "ovf", 32'(ovf_trap), 32'(e.eo));
            chk(unf_trap === e.eu, e.tag, "unf", 32'(unf_trap), 32'(e.eu));
         end
      end
   end

   initial begin
      #2_000_000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      //   sv rs we wa     wd            ww wimd   ra ca ea   rb cb eb   cwp o u
      cyc(0, 0, 0, 5'd0,  0,            0, 8'h0,  0, 1, 0,   8, 1, 0,   7, 0, 0, "R10 R9 reset");
      cyc(0, 0, 1, 5'd8,  A1,           0, 8'h0,  8, 1, A1,  0, 1, 0,   7, 0, 0, "R12 bypass");
      cyc(0, 0, 1, 5'd0,  32'hFFFF_FFFF,0, 8'h0,  0, 1, 0,   8, 1, A1,  7, 0, 0, "R2 r0 write cycle");
      cyc(0, 0, 0, 5'd0,  0,            0, 8'h0,  0, 1, 0,  16, 1, 0,   7, 0, 0, "R2 R10 r0 after write");
      cyc(0, 0, 1, 5'd1,  G1,           0, 8'h0,  1, 1, G1,  0, 0, 0,   7, 0, 0, "R12 global write");
      cyc(0, 0, 1, 5'd15, RET,          0, 8'h0,  1, 1, G1,  0, 0, 0,   7, 0, 0, "R8 write o7");
      cyc(0, 0, 1, 5'd16, L7,           0, 8'h0, 15, 1, RET, 0, 0, 0,   7, 0, 0, "R8 o7 held");
      cyc(1, 0, 0, 5'd0,  0,            0, 8'h0, 15, 1, RET,16, 1, L7,  7, 0, 0, "R5 save to invalid");
      cyc(0, 0, 0, 5'd0,  0,            0, 8'h0, 15, 1, RET, 0, 0, 0,   7, 1, 0, "R5 R6 overflow");
      cyc(0, 0, 0, 5'd0,  0,            0, 8'h0,  0, 0, 0,   0, 0, 0,   7, 0, 0, "R6 pulse ends");
      cyc(0, 0, 0, 5'd0,  0,            1, 8'h01, 0, 0, 0,   0, 0, 0,   7, 0, 0, "R5 mask load");
      cyc(1, 0, 0, 5'd0,  0,            0, 8'h0, 16, 1, L7,  0, 0, 0,   7, 0, 0, "R11 old window");
      cyc(0, 0, 0, 5'd0,  0,            0, 8'h0, 31, 1, RET,24, 1, A1,  6, 0, 0, "R8 R7 save ok");
      cyc(0, 0, 0, 5'd0,  0,            0, 8'h0,  1, 1, G1, 16, 1, 0,   6, 0, 0, "R1 R7 private");
      cyc(0, 0, 1, 5'd16, L6,           0, 8'h0, 16, 1, L6,  0, 0, 0,   6, 0, 0, "R12 local write");
      cyc(0, 1, 0, 5'd0,  0,            0, 8'h0, 16, 1, L6,  0, 0, 0,   6, 0, 0, "R11 restore cycle");
      cyc(0, 0, 0, 5'd0,  0,            0, 8'h0, 16, 1, L7, 15, 1, RET, 7, 0, 0, "R4 back home");
      cyc(0, 1, 0, 5'd0,  0,            0, 8'h0,  8, 1, A1,  0, 0, 0,   7, 0, 0, "R4 restore invalid");
      cyc(0, 0, 0, 5'd0,  0,            0, 8'h0,  0, 0, 0,   0, 0, 0,   7, 0, 1, "R5 R6 underflow");
      cyc(0, 0, 0, 5'd0,  0,            0, 8'h0,  0, 0, 0,   0, 0, 0,   7, 0, 0, "R6 pulse ends");
      for (int k = 7; k >= 2; k--)
         cyc(1, 0, 0, 5'd0, 0,          0, 8'h0,  1, 1, G1,  0, 0, 0,   k, 0, 0, "R3 R1 descend");
      cyc(1, 0, 0, 5'd0,  0,            0, 8'h0,  0, 0, 0,   0, 0, 0,   1, 0, 0, "R5 save at 1");
      cyc(0, 0, 0, 5'd0,  0,            0, 8'h0,  0, 0, 0,   0, 0, 0,   1, 1, 0, "R5 R6 overflow at 1");
      cyc(0, 0, 0, 5'd0,  0,            1, 8'h20, 0, 0, 0,   0, 0, 0,   1, 0, 0, "R5 mask reload");
      cyc(1, 0, 0, 5'd0,  0,            0, 8'h0,  0, 0, 0,   0, 0, 0,   1, 0, 0, "R3 save 1");
      cyc(1, 0, 0, 5'd0,  0,            0, 8'h0,  0, 0, 0,   0, 0, 0,   0, 0, 0, "R3 save 0");
      cyc(0, 1, 0, 5'd0,  0,            0, 8'h0,  8, 1, A1,  0, 0, 0,   7, 0, 0, "R3 R9 wrap down");
      cyc(0, 0, 0, 5'd0,  0,            0, 8'h0,  0, 0, 0,   0, 0, 0,   0, 0, 0, "R3 wrap up");
      cyc(1, 1, 0, 5'd0,  0,            0, 8'h0,  0, 0, 0,   0, 0, 0,   0, 0, 0, "R13 both");
      cyc(0, 0, 0, 5'd0,  0,            0, 8'h0,  0, 0, 0,   0, 0, 0,   0, 0, 0, "R13 no change");
      repeat (3) @(negedge clk);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule